// File: doc/BRIEF.md
# Six-Mode Interval Counter Channel

This block is one channel of a programmable interval timer. It keeps a 16-bit count register, which takes each complete count that is written, and a counter element that does the actual counting. From these it drives a single output line. Counting advances only on system clock cycles where the timer-tick enable is high. The gate input either holds counting or starts and restarts it, depending on the selected mode. Bus decoding, byte assembly and count readback stay outside the block. The surrounding logic supplies four things: the 3-bit mode, a pulse when a control word is written, a pulse when a partial (first-byte) count is written, and a pulse with the assembled 16-bit value when a complete count is written.

Six behaviours are available: an output that rises when the count runs out, a gate-triggered retriggerable one-shot, a rate generator that pulses low once per period, a square-wave generator, and two single-tick strobes (one started by a software write, one by a gate edge). Mode codes 6 and 7 act as codes 2 and 3. A written count of zero gives the full range. Counting can be binary or four-digit BCD. A null-count flag shows that a written count has not yet moved into the counter element.

Top module: `tmr_channel`

## Requirements
- R1: A control-word pulse sets the output low when the mode is 0 (mode codes: 0 terminal count, 1 one-shot, 2 rate, 3 square, 4 software strobe, 5 hardware strobe). For any other mode it sets the output high. It also sets the null-count flag.
- R2: In mode 0, a complete count N loads on the first tick after the write without decrementing. The output rises on the tick N+1 ticks after the write, and stays high after that.
- R3: In mode 0, a partial-count pulse drives the output low on the next cycle and freezes counting. A following complete count N raises the output N+1 ticks after that write.
- R4: In modes 0 and 4, a low gate stops decrementing but does not change the output. A count written while the gate is low still loads on the next tick.
- R5: In mode 1, the count loads on the first tick after a gate rising edge. The output then stays low for N ticks. A new rising edge during the pulse reloads the count and lengthens the pulse.
- R6: In mode 2, the output is low for one tick when the counter element holds 1, and the count reloads on the following tick. This gives a period of N ticks, with the first low output N ticks after the write.
- R7: In modes 2 and 3, a low gate forces the output high on the next cycle and stops counting. A gate rising edge reloads the count on the following tick.
- R8: In mode 3, an even N gives N/2 ticks high and N/2 ticks low. An odd N gives (N+1)/2 ticks high and (N-1)/2 ticks low.
- R9: In modes 2 and 3, a count written while counting takes effect only at the next reload, so the current cycle finishes with the old count.
- R10: In modes 4 and 5, the output goes low for exactly one tick when the count reaches 0, and does not pulse again until the next load. Mode 5 loads only on the tick after a gate rising edge.
- R11: A count of 0 gives 65536 ticks in binary and 10000 ticks in BCD. In BCD, a borrow runs across the 4-bit decimal digits.
- R12: The null-count flag is set by a complete count write and cleared on the tick that moves the count into the counter element.
- R13: With the tick enable low, the counter does not load, decrement or change the output. The one exception is the gate override of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer tick enable; each high cycle is one timer clock |
| gate_i | input | 1 | Gate input, sampled on the system clock |
| mode_i | input | 3 | Counting mode, held stable after the control-word pulse |
| bcd_i | input | 1 | 1 selects four-digit BCD counting |
| cw_wr_i | input | 1 | Control word written (one-cycle pulse) |
| cnt_part_i | input | 1 | First byte of a two-byte count written (one-cycle pulse) |
| cnt_done_i | input | 1 | Complete count written (one-cycle pulse) |
| cnt_val_i | input | 16 | Complete count value, valid with cnt_done_i |
| out_o | output | 1 | Channel output |
| null_o | output | 1 | Written count not yet moved into the counter element |

## Verification
A write or gate change is captured on clock edge E. Pulses to the output from control and partial writes, and the gate override, appear in the sample taken just after E+1 at the latest. Loading takes one tick after a count write. For a gate trigger it takes one tick after the edge that registers the rising gate. Every later output change is then a whole number of ticks after that load. The bench works out the due cycle for each output and null-flag value from these rules. Each expectation is queued with its absolute cycle number before that cycle arrives. The monitor compares each item a quarter period after its edge, so no comparison races the edge that produces the value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    M_TCINT   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmode_e;

  // codes 6 and 7 fold onto rate and square
  function automatic tmode_e fold_mode(input logic [2:0] m);
    if (m[1]) return tmode_e'({1'b0, m[1:0]});
    return tmode_e'(m);
  endfunction

  // subtract one from a packed decimal value, wrapping 0 to all nines
  function automatic logic [CNT_W-1:0] bcd_less1(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic brw;
    r   = v;
    brw = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (brw) begin
        if (v[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                 input logic bcd, input logic two);
    logic [CNT_W-1:0] a;
    a = bcd ? bcd_less1(v) : v - CNT_W'(1);
    if (two) a = bcd ? bcd_less1(a) : a - CNT_W'(1);
    return a;
  endfunction
endpackage

// File: rtl/tmr_decr.sv
module tmr_decr
  import tmr_pkg::*;
(
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  input  logic             two_i,
  output logic [CNT_W-1:0] res_o
);
  assign res_o = step_down(val_i, bcd_i, two_i);
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic             cw_wr_i,
  input  logic             cnt_part_i,
  input  logic             cnt_done_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output logic             out_o,
  output logic             null_o
);
  logic [CNT_W-1:0] cr_q, ce_q, ce_dec, load_val;
  logic out_q, null_q, armed_q, pend_q, susp_q, trig_q, fired_q, odd_q;
  tmode_e md;
  logic gate_rise, periodic, strobe_md, act, ce_one, run_en, term_hit;
  logic per_term, per_trig, sq_flip;
  logic load_ev, dec_ev, strobe_hit, out_nx;

  tmr_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  tmr_decr u_decr (
    .val_i (ce_q),
    .bcd_i (bcd_i),
    .two_i (md == M_SQUARE),
    .res_o (ce_dec)
  );

  always_comb begin
    md        = fold_mode(mode_i);
    periodic  = (md == M_RATE) || (md == M_SQUARE);
    strobe_md = (md == M_SWSTB) || (md == M_HWSTB);
    act       = tick_i & ~cw_wr_i;
    ce_one    = (ce_q == CNT_W'(1));
    case (md)
      M_TCINT:            run_en = armed_q & gate_i & ~susp_q;
      M_SWSTB:            run_en = armed_q & gate_i;
      M_ONESHOT, M_HWSTB: run_en = armed_q;
      default:            run_en = armed_q & gate_i & ~gate_rise;
    endcase
    if (md == M_SQUARE) term_hit = (ce_q == ((out_q && odd_q) ? '0 : CNT_W'(2)));
    else                term_hit = ce_one;
    per_term = run_en & term_hit;
    per_trig = trig_q & armed_q & gate_i;
    sq_flip  = per_term & ~pend_q & ~per_trig;
    case (md)
      M_TCINT, M_SWSTB:   load_ev = act & pend_q;
      M_ONESHOT, M_HWSTB: load_ev = act & trig_q & armed_q;
      default:            load_ev = act & (pend_q | per_trig | per_term);
    endcase
    dec_ev     = act & run_en & ~load_ev;
    strobe_hit = dec_ev & ce_one & ~fired_q & strobe_md;
    load_val   = (md == M_SQUARE) ? {cr_q[CNT_W-1:1], 1'b0} : cr_q;
  end

  always_comb begin
    out_nx = out_q;
    if (act) begin
      case (md)
        M_TCINT:   if (dec_ev && ce_one) out_nx = 1'b1;
        M_ONESHOT: begin
          if (load_ev) out_nx = 1'b0;
          else if (dec_ev && ce_one) out_nx = 1'b1;
        end
        M_RATE: begin
          if (load_ev) out_nx = 1'b1;
          else if (dec_ev) out_nx = (ce_q != CNT_W'(2));
        end
        M_SQUARE:  if (load_ev) out_nx = sq_flip ? ~out_q : 1'b1;
        default:   out_nx = ~strobe_hit;
      endcase
    end
    if (periodic && !gate_i) out_nx = 1'b1;
    if (cw_wr_i) out_nx = (md != M_TCINT);
    else if (md == M_TCINT && (cnt_part_i || cnt_done_i)) out_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q    <= '0;
      ce_q    <= '0;
      out_q   <= 1'b1;
      null_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      susp_q  <= 1'b0;
      trig_q  <= 1'b0;
      fired_q <= 1'b1;
      odd_q   <= 1'b0;
    end else begin
      out_q <= out_nx;
      if (cw_wr_i)        trig_q <= 1'b0;
      else if (gate_rise) trig_q <= 1'b1;
      else if (tick_i)    trig_q <= 1'b0;

      if (load_ev) begin
        ce_q    <= load_val;
        odd_q   <= cr_q[0];
        pend_q  <= 1'b0;
        null_q  <= 1'b0;
        fired_q <= 1'b0;
      end else if (dec_ev) begin
        ce_q <= ce_dec;
        if (strobe_hit) fired_q <= 1'b1;
      end

      if (cw_wr_i) begin
        ce_q    <= '0;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
        susp_q  <= 1'b0;
        null_q  <= 1'b1;
        fired_q <= 1'b1;
      end else begin
        if (cnt_part_i && md == M_TCINT) susp_q <= 1'b1;
        if (cnt_done_i) begin
          cr_q    <= cnt_val_i;
          null_q  <= 1'b1;
          armed_q <= 1'b1;
          susp_q  <= 1'b0;
          if (md == M_TCINT || md == M_SWSTB || (periodic && !armed_q)) pend_q <= 1'b1;
        end
      end
    end
  end

  assign out_o  = out_q;
  assign null_o = null_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       gate_i,
  input logic [2:0] mode_i,
  input logic       cw_wr_i,
  input logic       cnt_part_i,
  input logic       cnt_done_i,
  input logic       out_o,
  input logic       null_o,
  input logic       load_ev
);
  tmode_e m;
  logic per, stb, quiet;
  assign m     = fold_mode(mode_i);
  assign per   = (m == M_RATE) || (m == M_SQUARE);
  assign stb   = (m == M_SWSTB) || (m == M_HWSTB);
  assign quiet = !cw_wr_i && !cnt_part_i && !cnt_done_i;

  p_cw_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr_i && m == M_TCINT |=> !out_o);
  p_cw_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr_i && m != M_TCINT |=> out_o);
  p_cw_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr_i |=> null_o);
  p_wr_null_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_done_i |=> null_o);
  p_load_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev && quiet |=> !null_o);
  p_tc_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m == M_TCINT && out_o && quiet |=> out_o);
  p_part_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m == M_TCINT && cnt_part_i |=> !out_o);
  p_gate_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per && !gate_i |=> out_o);
  p_strobe_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb && !out_o && tick_i && !cw_wr_i |=> out_o);
  p_notick_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && quiet && !(per && !gate_i) |=> $stable(out_o));
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .gate_i     (gate_i),
  .mode_i     (mode_i),
  .cw_wr_i    (cw_wr_i),
  .cnt_part_i (cnt_part_i),
  .cnt_done_i (cnt_done_i),
  .out_o      (out_o),
  .null_o     (null_o),
  .load_ev    (load_ev)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam int CLK_P = 10;
  localparam bit K_OUT = 1'b0;
  localparam bit K_NUL = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, gate = 1'b1, bcd = 1'b0;
  logic cw_wr = 1'b0, cnt_part = 1'b0, cnt_done = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [15:0] cnt_val = '0;
  logic out_w, null_w;

  typedef struct { int at; bit kind; bit val; string req; } exp_t;
  exp_t exp_q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate), .mode_i(mode),
    .bcd_i(bcd), .cw_wr_i(cw_wr), .cnt_part_i(cnt_part), .cnt_done_i(cnt_done),
    .cnt_val_i(cnt_val), .out_o(out_w), .null_o(null_w)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor: compare every queued item a quarter period after its edge
  always @(posedge clk) begin
    cyc++;
    #(CLK_P/4);
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at <= cyc) begin
        logic act;
        act = (exp_q[i].kind == K_OUT) ? out_w : null_w;
        n_chk++;
        if (act !== exp_q[i].val) begin
          n_bad++;
          $display("FAIL %s cycle %0d %s actual %0b expected %0b", exp_q[i].req, cyc,
                   (exp_q[i].kind == K_OUT) ? "out" : "null", act, exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic expect_at(input int at, input bit kind, input bit val, input string req);
    exp_t e;
    e.at = at; e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic cw(input logic [2:0] m, input logic b, output int c);
    @(negedge clk); mode = m; bcd = b; cw_wr = 1'b1;
    @(negedge clk); cw_wr = 1'b0; c = cyc;
  endtask

  task automatic wcnt(input logic [15:0] v, output int w);
    @(negedge clk); cnt_val = v; cnt_done = 1'b1;
    @(negedge clk); cnt_done = 1'b0; w = cyc;
  endtask

  task automatic wpart(output int p);
    @(negedge clk); cnt_part = 1'b1;
    @(negedge clk); cnt_part = 1'b0; p = cyc;
  endtask

  task automatic setg(input logic b, output int g);
    @(negedge clk); gate = b; g = cyc + 1;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c, w, p, g, g2, r;
    expect_at(2, K_OUT, 1'b1, "reset");
    expect_at(2, K_NUL, 1'b0, "reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R12: mode 0, N=4
    cw(3'd0, 1'b0, c);
    expect_at(c + 1, K_OUT, 1'b0, "R1");
    expect_at(c + 1, K_NUL, 1'b1, "R1");
    wcnt(16'd4, w);
    expect_at(w + 1, K_NUL, 1'b0, "R12");
    expect_at(w + 4, K_OUT, 1'b0, "R2");
    expect_at(w + 5, K_OUT, 1'b1, "R2");
    expect_at(w + 20, K_OUT, 1'b1, "R2");
    wait_to(w + 21);

    // R3: partial write suspends and forces low
    wpart(p);
    expect_at(p + 1, K_OUT, 1'b0, "R3");
    expect_at(p + 6, K_OUT, 1'b0, "R3");
    wait_to(p + 6);
    wcnt(16'd2, w);
    expect_at(w + 2, K_OUT, 1'b0, "R3");
    expect_at(w + 3, K_OUT, 1'b1, "R3");
    wait_to(w + 4);

    // R4: mode 0 gate low holds count, load still happens
    cw(3'd0, 1'b0, c);
    setg(1'b0, g);
    wcnt(16'd3, w);
    expect_at(w + 6, K_OUT, 1'b0, "R4");
    wait_to(w + 6);
    setg(1'b1, g);
    expect_at(g + 1, K_OUT, 1'b0, "R4");
    expect_at(g + 2, K_OUT, 1'b1, "R4");
    wait_to(g + 3);

    // R5 R12: one-shot with retrigger
    setg(1'b0, g);
    cw(3'd1, 1'b0, c);
    expect_at(c + 1, K_OUT, 1'b1, "R1");
    wcnt(16'd3, w);
    expect_at(w + 2, K_NUL, 1'b1, "R12");
    expect_at(w + 4, K_OUT, 1'b1, "R5");
    wait_to(w + 4);
    setg(1'b1, g);
    expect_at(g + 1, K_OUT, 1'b0, "R5");
    expect_at(g + 2, K_NUL, 1'b0, "R12");
    expect_at(g + 4, K_OUT, 1'b0, "R5");
    expect_at(g + 5, K_OUT, 1'b0, "R5");
    expect_at(g + 6, K_OUT, 1'b1, "R5");
    setg(1'b0, g2);
    setg(1'b1, g2);
    wait_to(g + 7);

    // R6 R9: rate generator, new count waits for reload
    cw(3'd2, 1'b0, c);
    expect_at(c + 1, K_OUT, 1'b1, "R1");
    wcnt(16'd3, w);
    expect_at(w + 2, K_OUT, 1'b1, "R6");
    expect_at(w + 3, K_OUT, 1'b0, "R6");
    expect_at(w + 4, K_OUT, 1'b1, "R6");
    expect_at(w + 6, K_OUT, 1'b0, "R6");
    expect_at(w + 7, K_OUT, 1'b1, "R6");
    expect_at(w + 9, K_OUT, 1'b1, "R9");
    expect_at(w + 10, K_OUT, 1'b1, "R9");
    expect_at(w + 11, K_OUT, 1'b0, "R9");
    expect_at(w + 12, K_OUT, 1'b1, "R9");
    wait_to(w + 4);
    wcnt(16'd5, p);

    // R7: gate low forces high, rising edge reloads
    wait_to(w + 15);
    setg(1'b0, g);
    expect_at(g, K_OUT, 1'b1, "R7");
    expect_at(g + 3, K_OUT, 1'b1, "R7");
    wait_to(g + 3);
    setg(1'b1, r);
    expect_at(r + 4, K_OUT, 1'b1, "R7");
    expect_at(r + 5, K_OUT, 1'b0, "R7");
    wait_to(r + 6);

    // R8: square wave, even then odd
    cw(3'd3, 1'b0, c);
    wcnt(16'd4, w);
    expect_at(w + 2, K_OUT, 1'b1, "R8");
    expect_at(w + 3, K_OUT, 1'b0, "R8");
    expect_at(w + 4, K_OUT, 1'b0, "R8");
    expect_at(w + 5, K_OUT, 1'b1, "R8");
    expect_at(w + 7, K_OUT, 1'b0, "R8");
    wait_to(w + 8);
    cw(3'd3, 1'b0, c);
    wcnt(16'd5, w);
    expect_at(w + 3, K_OUT, 1'b1, "R8");
    expect_at(w + 4, K_OUT, 1'b0, "R8");
    expect_at(w + 5, K_OUT, 1'b0, "R8");
    expect_at(w + 6, K_OUT, 1'b1, "R8");
    expect_at(w + 8, K_OUT, 1'b1, "R8");
    expect_at(w + 9, K_OUT, 1'b0, "R8");
    wait_to(w + 10);

    // R10: software strobe, then R4 for mode 4 with gate low
    cw(3'd4, 1'b0, c);
    wcnt(16'd3, w);
    expect_at(w + 3, K_OUT, 1'b1, "R10");
    expect_at(w + 4, K_OUT, 1'b0, "R10");
    expect_at(w + 5, K_OUT, 1'b1, "R10");
    expect_at(w + 12, K_OUT, 1'b1, "R10");
    wait_to(w + 13);
    cw(3'd4, 1'b0, c);
    setg(1'b0, g);
    wcnt(16'd2, w);
    expect_at(w + 6, K_OUT, 1'b1, "R4");
    wait_to(w + 6);
    setg(1'b1, g);
    expect_at(g, K_OUT, 1'b1, "R4");
    expect_at(g + 1, K_OUT, 1'b0, "R10");
    expect_at(g + 2, K_OUT, 1'b1, "R10");
    wait_to(g + 3);

    // R10: hardware strobe waits for gate edge
    setg(1'b0, g);
    cw(3'd5, 1'b0, c);
    wcnt(16'd2, w);
    expect_at(w + 5, K_OUT, 1'b1, "R10");
    wait_to(w + 5);
    setg(1'b1, g);
    expect_at(g + 2, K_OUT, 1'b1, "R10");
    expect_at(g + 3, K_OUT, 1'b0, "R10");
    expect_at(g + 4, K_OUT, 1'b1, "R10");
    wait_to(g + 5);

    // R13: no tick, no progress
    cw(3'd0, 1'b0, c);
    @(negedge clk); tick = 1'b0;
    wcnt(16'd2, w);
    expect_at(w + 8, K_OUT, 1'b0, "R13");
    expect_at(w + 8, K_NUL, 1'b1, "R13");
    wait_to(w + 8);
    @(negedge clk); tick = 1'b1; r = cyc + 1;
    expect_at(r + 1, K_OUT, 1'b0, "R13");
    expect_at(r + 2, K_OUT, 1'b1, "R13");
    wait_to(r + 3);

    // R11: BCD borrow across digits, then zero in BCD and binary
    cw(3'd0, 1'b1, c);
    wcnt(16'h0100, w);
    expect_at(w + 100, K_OUT, 1'b0, "R11");
    expect_at(w + 101, K_OUT, 1'b1, "R11");
    wait_to(w + 102);
    cw(3'd0, 1'b1, c);
    wcnt(16'h0000, w);
    expect_at(w + 10000, K_OUT, 1'b0, "R11");
    expect_at(w + 10001, K_OUT, 1'b1, "R11");
    wait_to(w + 10002);
    cw(3'd0, 1'b0, c);
    wcnt(16'h0000, w);
    expect_at(w + 65536, K_OUT, 1'b0, "R11");
    expect_at(w + 65537, K_OUT, 1'b1, "R11");
    wait_to(w + 65538);

    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule